// File: doc/BRIEF.md
# Debug Instruction Injection Port for a DMA Engine

This block lets software hand one instruction at a time to a DMA engine's manager thread or to one of its channel threads. Software loads two instruction registers, then writes zero to a command register to trigger the instruction. While the port works on it, a busy flag in the status register reads 1. Software polls that flag until it reads 0 before it loads anything new.

The port recognises two injected instructions. A start goes to the manager and launches a channel at a 32-bit program address. A kill goes to a channel thread and stops that channel. For each one the port raises a one-cycle strobe with the channel number and, for a start, the program address. A separate channel block consumes these strobes. A start aimed at a channel that is not stopped is refused. Any other byte pattern is rejected. Both refusals set sticky bits in a fault register, which software clears by writing ones.

Top module: `dbg_inject_port`

## Requirements
- R1: After reset the status busy bit (offset 0x00, bit 0), both strobes, both instruction registers and the fault register all read 0.
- R2: A write of value 0 to the command register (offset 0x04) while idle sets busy in the next cycle. Busy holds for exactly two cycles and then returns to 0.
- R3: A write of any nonzero value to the command register has no effect. Busy stays 0 and no strobe follows.
- R4: A command write while busy is ignored. Exactly one strobe results from the original command.
- R5: Writes to instruction register 0 (offset 0x08) or instruction register 1 (offset 0x0C) while busy are ignored.
- R6: A start is instruction register 0 with bit 0 = 0 (manager), bits [23:16] = 0xA0 and the channel in bits [31:24]. It yields `start_o` high for exactly one cycle, in the second cycle after the command write. In that cycle `chan_o` is the channel and `addr_o` is instruction register 1.
- R7: A kill is instruction register 0 with bit 0 = 1 (channel thread), bits [23:16] = 0x01 and the channel in bits [10:8]. It yields `kill_o` for one cycle with `chan_o` set, timed as in R6.
- R8: A start whose channel is not stopped (`chan_stopped[ch]` = 0), or whose channel number is NCH or more, gives no strobe and sets fault bit 1 (operand invalid).
- R9: Any other instruction-0 pattern gives no strobe and sets fault bit 30 (unsupported debug instruction).
- R10: Fault bits (offset 0x10) are sticky and clear only when 1 is written to them. A fault set in the same cycle as a clear write stays set.
- R11: `start_o` and `kill_o` are never high together, and each is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| chan_stopped | input | NCH | Per-channel stopped indication from the channel block |
| start_o | output | 1 | One-cycle channel start strobe |
| kill_o | output | 1 | One-cycle channel kill strobe |
| chan_o | output | CHW | Target channel of the strobe |
| addr_o | output | 32 | Program address for a start |

## Verification
Two functions can fall in the same cycle. The first is the fault update at the end of decode. The second is a software write that clears faults; a second command write or an instruction-register write arriving mid-decode is a related case. The bench provokes the fault case by issuing a rejected instruction and placing a write of all ones to the fault register on the very edge where decode finishes. It expects the new fault bit to survive. In the same way, it places a repeat command write and an instruction-register write inside the busy window. It judges them by counting strobes, checking the strobe address and reading back the registers.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
    localparam int OFS_STATUS = 'h00;
    localparam int OFS_CMD    = 'h04;
    localparam int OFS_INSTR0 = 'h08;
    localparam int OFS_INSTR1 = 'h0C;
    localparam int OFS_FAULT  = 'h10;

    localparam logic [7:0] OPC_START = 8'hA0;
    localparam logic [7:0] OPC_KILL  = 8'h01;

    localparam int FLT_OPERAND = 1;
    localparam int FLT_DBGINS  = 30;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_DEC,
        SEQ_ISS
    } seq_state_e;

    typedef enum logic [1:0] {
        DK_START,
        DK_KILL,
        DK_BADOPND,
        DK_BADINS
    } dec_kind_e;
endpackage

// File: rtl/dbg_inject_regs.sv
module dbg_inject_regs
    import dbg_inject_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic [31:0]       fault,
    output logic [31:0]       rdata,
    output logic              cmd_fire,
    output logic [31:0]       fault_clr,
    output logic              thr_sel,
    output logic [2:0]        kill_ch,
    output logic [7:0]        op_byte,
    output logic [7:0]        arg_byte,
    output logic [31:0]       prog_addr
);
    typedef struct packed {
        logic [31:0] ins0;
        logic [31:0] ins1;
    } regs_t;

    regs_t r_d, r_q;

    logic sel_cmd, sel_i0, sel_i1, sel_flt;

    always_comb begin
        sel_cmd = (addr == ADDR_W'(OFS_CMD));
        sel_i0  = (addr == ADDR_W'(OFS_INSTR0));
        sel_i1  = (addr == ADDR_W'(OFS_INSTR1));
        sel_flt = (addr == ADDR_W'(OFS_FAULT));

        r_d = r_q;
        if (wr_en && !busy && sel_i0) r_d.ins0 = wdata;
        if (wr_en && !busy && sel_i1) r_d.ins1 = wdata;

        cmd_fire  = wr_en && sel_cmd && !busy && (wdata == 32'd0);
        fault_clr = (wr_en && sel_flt) ? wdata : 32'd0;

        unique case (1'b1)
            (addr == ADDR_W'(OFS_STATUS)): rdata = {31'd0, busy};
            sel_i0:                        rdata = r_q.ins0;
            sel_i1:                        rdata = r_q.ins1;
            sel_flt:                       rdata = fault;
            default:                       rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign thr_sel   = r_q.ins0[0];
    assign kill_ch   = r_q.ins0[10:8];
    assign op_byte   = r_q.ins0[23:16];
    assign arg_byte  = r_q.ins0[31:24];
    assign prog_addr = r_q.ins1;

    // R5
    instr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q));
endmodule

// File: rtl/dbg_inject_decode.sv
module dbg_inject_decode
    import dbg_inject_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           thr_sel,
    input  logic [2:0]     kill_ch,
    input  logic [7:0]     op_byte,
    input  logic [7:0]     arg_byte,
    input  logic [NCH-1:0] chan_stopped,
    output dec_kind_e      kind,
    output logic [CHW-1:0] chan
);
    logic start_in_range, kill_in_range;

    always_comb begin
        start_in_range = (32'(arg_byte) < NCH);
        kill_in_range  = (32'(kill_ch) < NCH);
        kind = DK_BADINS;
        chan = '0;
        if (!thr_sel && op_byte == OPC_START) begin
            chan = arg_byte[CHW-1:0];
            if (start_in_range && chan_stopped[arg_byte[CHW-1:0]]) kind = DK_START;
            else                                                   kind = DK_BADOPND;
        end else if (thr_sel && op_byte == OPC_KILL) begin
            chan = kill_ch[CHW-1:0];
            kind = kill_in_range ? DK_KILL : DK_BADOPND;
        end
    end
endmodule

// File: rtl/dbg_inject_seq.sv
module dbg_inject_seq
    import dbg_inject_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_fire,
    input  logic [31:0]    fault_clr,
    input  dec_kind_e      kind,
    input  logic [CHW-1:0] dec_chan,
    input  logic [31:0]    prog_addr,
    output logic           busy,
    output logic [31:0]    fault,
    output logic           start_o,
    output logic           kill_o,
    output logic [CHW-1:0] chan_o,
    output logic [31:0]    addr_o
);
    typedef struct packed {
        seq_state_e     st;
        logic           start;
        logic           kill;
        logic [CHW-1:0] chan;
        logic [31:0]    addr;
        logic [31:0]    flt;
    } seq_t;

    seq_t s_d, s_q;
    logic [31:0] flt_set;

    always_comb begin
        s_d     = s_q;
        flt_set = 32'd0;
        s_d.start = 1'b0;
        s_d.kill  = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: if (cmd_fire) s_d.st = SEQ_DEC;
            SEQ_DEC: begin
                s_d.st = SEQ_ISS;
                unique case (kind)
                    DK_START: begin
                        s_d.start = 1'b1;
                        s_d.chan  = dec_chan;
                        s_d.addr  = prog_addr;
                    end
                    DK_KILL: begin
                        s_d.kill = 1'b1;
                        s_d.chan = dec_chan;
                    end
                    DK_BADOPND: flt_set[FLT_OPERAND] = 1'b1;
                    default:    flt_set[FLT_DBGINS]  = 1'b1;
                endcase
            end
            default: s_d.st = SEQ_IDLE;
        endcase
        s_d.flt = (s_q.flt & ~fault_clr) | flt_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, start: 1'b0, kill: 1'b0,
                             chan: '0, addr: 32'd0, flt: 32'd0};
        else        s_q <= s_d;
    end

    assign busy    = (s_q.st != SEQ_IDLE);
    assign fault   = s_q.flt;
    assign start_o = s_q.start;
    assign kill_o  = s_q.kill;
    assign chan_o  = s_q.chan;
    assign addr_o  = s_q.addr;

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && kill_o));
    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || kill_o) |-> busy);
    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R2
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> busy);
    // R9
    dbgins_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault[FLT_DBGINS]) |-> $past(s_q.st == SEQ_DEC));
endmodule

// File: rtl/dbg_inject_port.sv
module dbg_inject_port
    import dbg_inject_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 5,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NCH-1:0]    chan_stopped,
    output logic              start_o,
    output logic              kill_o,
    output logic [CHW-1:0]    chan_o,
    output logic [31:0]       addr_o
);
    logic           busy, cmd_fire, thr_sel;
    logic [31:0]    fault, fault_clr, prog_addr;
    logic [2:0]     kill_ch;
    logic [7:0]     op_byte, arg_byte;
    dec_kind_e      kind;
    logic [CHW-1:0] dec_chan;

    dbg_inject_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .fault(fault), .rdata(rdata), .cmd_fire(cmd_fire),
        .fault_clr(fault_clr), .thr_sel(thr_sel), .kill_ch(kill_ch),
        .op_byte(op_byte), .arg_byte(arg_byte), .prog_addr(prog_addr)
    );

    dbg_inject_decode #(.NCH(NCH)) u_dec (
        .thr_sel(thr_sel), .kill_ch(kill_ch), .op_byte(op_byte),
        .arg_byte(arg_byte), .chan_stopped(chan_stopped),
        .kind(kind), .chan(dec_chan)
    );

    dbg_inject_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .fault_clr(fault_clr),
        .kind(kind), .dec_chan(dec_chan), .prog_addr(prog_addr),
        .busy(busy), .fault(fault), .start_o(start_o), .kill_o(kill_o),
        .chan_o(chan_o), .addr_o(addr_o)
    );
endmodule

// File: tb/dbg_inject_port_bench.sv
`timescale 1ns/1ps
module dbg_inject_port_bench;
    localparam int NCH = 8;
    localparam int AW  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] chan_stopped = '1;
    logic        start_o, kill_o;
    logic [2:0]  chan_o;
    logic [31:0] addr_o;

    int total = 0;
    int bad = 0;
    int n_start = 0;
    int n_kill = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dbg_inject_port u_dbg_inject_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chan_stopped(chan_stopped), .start_o(start_o),
        .kill_o(kill_o), .chan_o(chan_o), .addr_o(addr_o)
    );

    always @(negedge clk) begin
        if (start_o) n_start++;
        if (kill_o)  n_kill++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a);
        #0.5;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_faults();
        logic [31:0] v;
        wr('h10, 32'hFFFF_FFFF);
        rd('h10, v);
        check("R10 clear", v, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd('h00, v); check("R1 busy", v, 0);
        rd('h08, v); check("R1 instr0", v, 0);
        rd('h0C, v); check("R1 instr1", v, 0);
        rd('h10, v); check("R1 fault", v, 0);
        check("R1 strobes", {30'd0, start_o, kill_o}, 0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        int s0;
        s0 = n_start;
        chan_stopped = '1;
        wr('h08, 32'h05A0_0000);
        wr('h0C, 32'h8000_1234);
        wr('h04, 0);
        rd('h00, v); check("R2 busy c1", v, 1);
        check("R6 no early strobe", {31'd0, start_o}, 0);
        @(negedge clk);
        rd('h00, v); check("R2 busy c2", v, 1);
        check("R6 start", {31'd0, start_o}, 1);
        check("R6 chan", {29'd0, chan_o}, 5);
        check("R6 addr", addr_o, 32'h8000_1234);
        check("R11 no kill", {31'd0, kill_o}, 0);
        @(negedge clk);
        rd('h00, v); check("R2 idle", v, 0);
        check("R6 one pulse", n_start - s0, 1);
    endtask

    task automatic t_kill();
        logic [31:0] v;
        int k0;
        k0 = n_kill;
        wr('h08, 32'h0001_0601);
        wr('h04, 0);
        @(negedge clk);
        check("R7 kill", {31'd0, kill_o}, 1);
        check("R7 chan", {29'd0, chan_o}, 6);
        check("R11 no start", {31'd0, start_o}, 0);
        @(negedge clk);
        check("R7 one pulse", n_kill - k0, 1);
        rd('h10, v); check("R7 no fault", v, 0);
    endtask

    task automatic t_operand();
        logic [31:0] v;
        int s0;
        s0 = n_start;
        chan_stopped = ~8'h08;
        wr('h08, 32'h03A0_0000);
        wr('h04, 0);
        idle(3);
        check("R8 busy chan no strobe", n_start - s0, 0);
        rd('h10, v); check("R8 fault bit1", v, 32'h0000_0002);
        clear_faults();
        chan_stopped = '1;
        wr('h08, 32'h09A0_0000);
        wr('h04, 0);
        idle(3);
        check("R8 range no strobe", n_start - s0, 0);
        rd('h10, v); check("R8 range fault", v, 32'h0000_0002);
        clear_faults();
    endtask

    task automatic t_badins();
        logic [31:0] v;
        int s0, k0;
        s0 = n_start; k0 = n_kill;
        wr('h08, 32'h00A0_0001);
        wr('h04, 0);
        idle(3);
        rd('h10, v); check("R9 start to channel", v, 32'h4000_0000);
        clear_faults();
        wr('h08, 32'h0001_0000);
        wr('h04, 0);
        idle(3);
        rd('h10, v); check("R9 kill to manager", v, 32'h4000_0000);
        check("R9 no strobe", (n_start - s0) + (n_kill - k0), 0);
        clear_faults();
    endtask

    task automatic t_nonzero_cmd();
        logic [31:0] v;
        int s0;
        s0 = n_start;
        wr('h08, 32'h02A0_0000);
        wr('h04, 32'h1);
        rd('h00, v); check("R3 not busy", v, 0);
        idle(3);
        check("R3 no strobe", n_start - s0, 0);
    endtask

    task automatic t_cmd_while_busy();
        logic [31:0] v;
        int k0;
        k0 = n_kill;
        wr('h08, 32'h0001_0201);
        wr('h04, 0);
        wr('h04, 0);
        wr('h04, 0);
        idle(4);
        check("R4 single kill", n_kill - k0, 1);
        rd('h00, v); check("R4 idle after", v, 0);
    endtask

    task automatic t_instr_while_busy();
        logic [31:0] v;
        int s0;
        s0 = n_start;
        wr('h08, 32'h01A0_0000);
        wr('h0C, 32'h0000_4000);
        wr('h04, 0);
        wr('h0C, 32'hDEAD_0000);
        check("R5 strobe addr", addr_o, 32'h0000_4000);
        wr('h08, 32'h0001_0001);
        rd('h0C, v); check("R5 instr1 kept", v, 32'h0000_4000);
        rd('h08, v); check("R5 instr0 kept", v, 32'h01A0_0000);
        check("R5 one start", n_start - s0, 1);
    endtask

    task automatic t_fault_race();
        logic [31:0] v;
        wr('h08, 32'h0077_0000);
        wr('h04, 0);
        wr('h10, 32'hFFFF_FFFF);
        rd('h10, v); check("R10 set beats clear", v, 32'h4000_0000);
        idle(2);
        rd('h10, v); check("R10 sticky", v, 32'h4000_0000);
        clear_faults();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_kill();
        t_operand();
        t_badins();
        t_nonzero_cmd();
        t_cmd_while_busy();
        t_instr_while_busy();
        t_fault_race();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule